// File: doc/BRIEF.md
# Display Serial Command Packet Word Builder

This block assembles one display serial interface command packet and presents it as a stream of 32-bit little-endian words for a downstream transmit sequencer. A single start pulse captures the packet header fields: a 2-bit channel number, a 6-bit packet type and a 16-bit length or parameter field. It also captures a flag that selects a short or a long packet. The block emits the header word one cycle later. The header word carries the 8-bit error-correcting code computed over the 24 header bits.

For a long packet the block then accepts payload bytes over a valid/ready handshake and folds each byte into a reflected 16-bit CRC. It appends the two checksum bytes after the payload. Payload and checksum bytes are packed four to a word, and the final partial word is zero-padded. The exact packet byte count is presented on its own output, so the sequencer can program the transfer length. A done pulse marks the last word of each packet. Start pulses that arrive while a packet is still being built are ignored.

Top module: `dsi_pkt_builder`

## Requirements
- R1: One cycle after an accepted start, `word_valid` is high and `word_data` holds the header word. Bits 7:0 are `{pkt_vc, pkt_type}` with the channel in bits 7:6. Bits 15:8 are the low byte of `pkt_len`. Bits 23:16 are the high byte of `pkt_len`. Bits 31:24 are the ECC.
- R2: The ECC is the XOR of the 6-bit signatures of all set header bits, with ECC bits 7:6 zero. The signatures for header bits 0 to 23 are 07 0b 0d 0e 13 15 16 19 1a 1c 23 25 26 29 2a 2c 31 32 34 38 1f 2f 37 3b (hex). Header bytes 05 00 00 give the word 0x0A000005.
- R3: The checksum is a CRC-16 with its register preset to 0xFFFF. It uses the reflected polynomial 0x8408 and takes each payload byte least significant bit first, with no final inversion. The ASCII bytes "123456789" give 0x6F91.
- R4: A long packet carries its checksum after the payload, low byte first. A long packet of zero length still carries the checksum 0xFFFF.
- R5: The bytes that follow the header are packed four per word, little-endian: the earliest byte goes in bits 7:0. A word is output one cycle after its fourth byte enters. The final word is zero-padded above its last byte.
- R6: From the cycle after an accepted start until the next accepted start, `total_bytes` reads 4 for a short packet and `pkt_len` + 6 for a long packet.
- R7: A short packet produces only the header word. `done` is high with that word, and `in_ready` stays low throughout.
- R8: `in_ready` is high exactly while payload bytes of a long packet remain outstanding. A cycle with `in_valid` low consumes nothing and changes no output.
- R9: `done` is high only with the last word of a packet. For a long packet the last word appears two cycles after the last payload byte is accepted, or two cycles after the header for a zero-length packet.
- R10: `busy` is high from the cycle after a long packet starts until the cycle that shows its last word. A start pulse while `busy` is high is ignored.
- R11: After reset, `word_valid`, `done`, `in_ready` and `busy` are low and `total_bytes` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet; fields below are captured |
| pkt_vc | input | 2 | Channel number |
| pkt_type | input | 6 | Packet type identifier |
| pkt_len | input | 16 | Payload length (long) or parameter bytes (short) |
| pkt_long | input | 1 | 1 selects a long packet with payload |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block accepts a payload byte |
| busy | output | 1 | Long packet under assembly |
| word_valid | output | 1 | `word_data` holds a packet word |
| word_data | output | 32 | Packet word, little-endian |
| done | output | 1 | Marks the last word of the packet |
| total_bytes | output | 17 | Packet length in bytes |

## Verification
A corrupted CRC register shows only in the final one or two bytes of the packet. These bytes reach the ports two cycles after the last payload byte. The bench therefore compares every word against a behavioural byte-queue model and also checks the fixed "123456789" vector. A miscounted byte lane or a wrong remaining-byte count shows within one word: a shifted lane, a word at the wrong cycle, a `done` that comes early or late, or an `in_ready` that does not match the model. A stale captured header shows in the header word and in `total_bytes` on the cycle after start. Start pulses sent in the middle of a packet check that the captured state is not disturbed.

// File: rtl/dsi_pkt_builder.sv
module dsi_pkt_builder #(
  parameter int VC_W  = 2,
  parameter int DT_W  = 6,
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VC_W-1:0]    pkt_vc,
  input  logic [DT_W-1:0]    pkt_type,
  input  logic [LEN_W-1:0]   pkt_len,
  input  logic               pkt_long,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic               busy,
  output logic               word_valid,
  output logic [31:0]        word_data,
  output logic               done,
  output logic [LEN_W:0]     total_bytes
);
  localparam int HDR_W = VC_W + DT_W + LEN_W;
  localparam int TOT_W = LEN_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_PAY, S_CS_LO, S_CS_HI} st_t;

  st_t              st;
  logic [LEN_W-1:0] remain;
  logic [15:0]      crc;
  logic [31:0]      acc;
  logic [1:0]       lane;

  function automatic logic [5:0] ecc_sig(input int i);
    case (i)
      0: return 6'h07;   1: return 6'h0b;   2: return 6'h0d;   3: return 6'h0e;
      4: return 6'h13;   5: return 6'h15;   6: return 6'h16;   7: return 6'h19;
      8: return 6'h1a;   9: return 6'h1c;  10: return 6'h23;  11: return 6'h25;
     12: return 6'h26;  13: return 6'h29;  14: return 6'h2a;  15: return 6'h2c;
     16: return 6'h31;  17: return 6'h32;  18: return 6'h34;  19: return 6'h38;
     20: return 6'h1f;  21: return 6'h2f;  22: return 6'h37;  default: return 6'h3b;
    endcase
  endfunction

  function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] b);
    logic [15:0] c;
    c = c_in;
    for (int k = 0; k < 8; k++)
      c = (c[0] ^ b[k]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  logic [HDR_W-1:0] hdr;
  logic [5:0]       ecc;
  assign hdr = {pkt_len, pkt_vc, pkt_type};

  always_comb begin
    ecc = '0;
    for (int i = 0; i < HDR_W; i++)
      if (hdr[i]) ecc = ecc ^ ecc_sig(i);
  end

  logic        take, feed, flush, last_byte;
  logic [7:0]  fbyte;
  logic [31:0] acc_nx;

  assign in_ready  = (st == S_PAY);
  assign busy      = (st != S_IDLE);
  assign take      = in_ready && in_valid;
  assign feed      = take || st == S_CS_LO || st == S_CS_HI;
  assign last_byte = (st == S_CS_HI);
  assign fbyte     = (st == S_PAY) ? in_data : (st == S_CS_LO) ? crc[7:0] : crc[15:8];
  assign acc_nx    = acc | ({24'b0, fbyte} << {lane, 3'b000});
  assign flush     = feed && (lane == 2'd3 || last_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      remain      <= '0;
      crc         <= 16'hFFFF;
      acc         <= '0;
      lane        <= '0;
      word_valid  <= 1'b0;
      word_data   <= '0;
      done        <= 1'b0;
      total_bytes <= '0;
    end else begin
      word_valid <= 1'b0;
      done       <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          word_valid  <= 1'b1;
          word_data   <= {2'b00, ecc, hdr};
          done        <= !pkt_long;
          total_bytes <= pkt_long ? TOT_W'(pkt_len) + TOT_W'(6) : TOT_W'(4);
          crc         <= 16'hFFFF;
          acc         <= '0;
          lane        <= '0;
          remain      <= pkt_len;
          if (pkt_long) st <= (pkt_len == '0) ? S_CS_LO : S_PAY;
        end
        S_PAY: if (take) begin
          crc    <= crc_byte(crc, in_data);
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) st <= S_CS_LO;
        end
        S_CS_LO: st <= S_CS_HI;
        default: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      endcase
      if (feed) begin
        lane <= lane + 1'b1;
        acc  <= flush ? '0 : acc_nx;
        if (flush) begin
          word_valid <= 1'b1;
          word_data  <= acc_nx;
        end
        if (last_byte) lane <= '0;
      end
    end
  end

  AST_DONE_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> word_valid);  // R9
  AST_READY_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);  // R8
  AST_HEADER_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> word_valid);  // R1
  AST_TOTAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(total_bytes));  // R6
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));  // R10
  AST_SHORT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !pkt_long) |=> (!in_ready && done));  // R7
endmodule

// File: tb/test_dsi_pkt_builder.sv
module test_dsi_pkt_builder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  pkt_vc = '0;
  logic [5:0]  pkt_type = '0;
  logic [15:0] pkt_len = '0;
  logic        pkt_long = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, busy, word_valid, done;
  logic [31:0] word_data;
  logic [16:0] total_bytes;

  always #10 clk = ~clk;

  dsi_pkt_builder i_dsi_pkt_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_vc(pkt_vc), .pkt_type(pkt_type),
    .pkt_len(pkt_len), .pkt_long(pkt_long), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .busy(busy), .word_valid(word_valid), .word_data(word_data),
    .done(done), .total_bytes(total_bytes));

  int total = 0, bad = 0;

  int          mst = 0;
  int          mrem = 0;
  logic [15:0] mcrc = 16'hFFFF;
  logic [7:0]  pk[$];
  logic        exp_wv = 0, exp_done = 0;
  logic [31:0] exp_wd = '0;
  logic [16:0] exp_total = '0;
  logic [31:0] seen[$];
  logic [7:0]  pay[$];

  function automatic logic [5:0] sig(input int i);
    logic [5:0] t[24] = '{6'h07,6'h0b,6'h0d,6'h0e,6'h13,6'h15,6'h16,6'h19,
                          6'h1a,6'h1c,6'h23,6'h25,6'h26,6'h29,6'h2a,6'h2c,
                          6'h31,6'h32,6'h34,6'h38,6'h1f,6'h2f,6'h37,6'h3b};
    return t[i];
  endfunction

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    int cc = c, bb = b;
    for (int k = 0; k < 8; k++) begin
      if (((cc ^ bb) & 1) != 0) cc = (cc >> 1) ^ 'h8408;
      else cc = cc >> 1;
      bb = bb >> 1;
    end
    return cc[15:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, a, e, $time);
    end
  endtask

  function automatic logic [31:0] pack_out();
    logic [31:0] w = '0;
    foreach (pk[i]) w = w | (32'(pk[i]) << (8 * i));
    pk.delete();
    return w;
  endfunction

  task automatic step(input bit s, input logic [1:0] v, input logic [5:0] d,
                      input logic [15:0] l, input bit lg, input bit iv, input logic [7:0] b);
    logic [23:0] h;
    logic [5:0]  e;
    @(negedge clk);
    chk(in_ready === (mst == 1), "R8 in_ready", 32'(in_ready), 32'(mst == 1));
    chk(busy === (mst != 0), "R10 busy", 32'(busy), 32'(mst != 0));
    chk(word_valid === exp_wv, "R5 word_valid", 32'(word_valid), 32'(exp_wv));
    chk(done === exp_done, "R9 done", 32'(done), 32'(exp_done));
    chk(total_bytes === exp_total, "R6 total_bytes", 32'(total_bytes), 32'(exp_total));
    if (exp_wv) begin
      chk(word_data === exp_wd, "R1/R5 word_data", word_data, exp_wd);
      seen.push_back(word_data);
    end
    start = s; pkt_vc = v; pkt_type = d; pkt_len = l; pkt_long = lg;
    in_valid = iv; in_data = b;
    exp_wv = 0; exp_done = 0;
    case (mst)
      0: if (s) begin
        h = {l, v, d};
        e = '0;
        for (int i = 0; i < 24; i++) if (h[i]) e = e ^ sig(i);
        exp_wv = 1; exp_wd = {2'b00, e, h}; exp_done = !lg;
        exp_total = lg ? 17'(l) + 17'd6 : 17'd4;
        mcrc = 16'hFFFF; pk.delete(); mrem = l;
        mst = !lg ? 0 : (l == 0) ? 2 : 1;
      end
      1: if (iv) begin
        mcrc = crc_upd(mcrc, b);
        pk.push_back(b);
        if (pk.size() == 4) begin exp_wv = 1; exp_wd = pack_out(); end
        mrem--;
        if (mrem == 0) mst = 2;
      end
      2: begin
        pk.push_back(mcrc[7:0]);
        if (pk.size() == 4) begin exp_wv = 1; exp_wd = pack_out(); end
        mst = 3;
      end
      default: begin
        pk.push_back(mcrc[15:8]);
        exp_wv = 1; exp_wd = pack_out(); exp_done = 1;
        mst = 0;
      end
    endcase
  endtask

  task automatic run_pkt(input logic [1:0] v, input logic [5:0] d, input logic [15:0] l,
                         input bit lg, input bit gappy, input bit poke);
    int idx = 0;
    seen.delete();
    step(1, v, d, l, lg, 0, 8'h00);
    if (lg) begin
      while (idx < l) begin
        bit iv = gappy ? ($urandom % 3 != 0) : 1'b1;
        bit ps = poke && ($urandom % 2 == 1);
        step(ps, 2'($urandom), 6'($urandom), 16'($urandom), 1'b0, iv, iv ? pay[idx] : 8'hEE);
        if (iv) idx++;
      end
      repeat (3) step(0, 0, 0, 0, 0, 0, 0);
    end else begin
      step(0, 0, 0, 0, 0, 1, 8'h55);
    end
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input int n, input bit ascii);
    pay.delete();
    for (int i = 0; i < n; i++) pay.push_back(ascii ? 8'(8'h31 + i) : 8'($urandom));
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!word_valid && !done && !in_ready && !busy, "R11 reset outputs",
        {28'b0, word_valid, done, in_ready, busy}, 32'h0);
    chk(total_bytes === '0, "R11 reset total", 32'(total_bytes), 32'h0);
    rst_n = 1'b1;

    run_pkt(2'd0, 6'h05, 16'h0000, 0, 0, 0);
    chk(seen.size() == 1 && seen[0] === 32'h0A000005, "R2 known ECC", seen[0], 32'h0A000005);
    chk(seen.size() == 1, "R7 short single word", seen.size(), 1);

    run_pkt(2'd1, 6'h15, 16'h3A29, 0, 0, 0);

    fill(9, 1);
    run_pkt(2'd0, 6'h39, 16'd9, 1, 0, 0);
    chk(seen.size() == 4, "R5 word count", seen.size(), 4);
    chk(seen[seen.size()-1] === 32'h006F9139, "R3 known CRC", seen[seen.size()-1], 32'h006F9139);

    pay.delete();
    run_pkt(2'd2, 6'h29, 16'd0, 1, 0, 0);
    chk(seen.size() == 2 && seen[1] === 32'h0000FFFF, "R4 empty checksum", seen[1], 32'h0000FFFF);

    for (int n = 1; n <= 10; n++) begin
      fill(n, 0);
      run_pkt(2'($urandom), 6'($urandom), 16'(n), 1, n > 4, n % 2 == 1);
    end
    fill(37, 0);
    run_pkt(2'd3, 6'h39, 16'd37, 1, 1, 1);

    for (int r = 0; r < 6; r++) begin
      fill(2 + r, 0);
      step(1, 2'd1, 6'h39, 16'(2 + r), 1, 0, 0);
      for (int i = 0; i < 2 + r; i++) step(0, 0, 0, 0, 0, 1, pay[i]);
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
    end
    step(1, 2'd2, 6'h05, 16'h1100, 0, 0, 0);
    repeat (3) step(0, 0, 0, 0, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule